// File: doc/BRIEF.md
# Filtered LFSR Keystream Generator

This block is the cipher engine of a low-frequency transponder link. It holds a 48-bit shift register that is seeded from a 48-bit secret key and a 32-bit serial number. A 32-round mixing phase then folds in a 32-bit initialisation vector and the upper key bits, using a two-level table-lookup filter. Once mixing is done, each accepted step moves the register one place through a fixed 16-tap linear feedback. The filter output of the new state is the keystream bit for that step.

The keystream is delivered in three forms. Each accepted step gives one bit. Every eighth bit completes a byte, with the first bit placed in the most significant position. A serial data path XORs one input bit with each keystream bit, so the same path encrypts and decrypts. A helper operation checks a 32-bit authenticator from the reader: it consumes the next 32 keystream bits on its own, and the word passes when it equals their bitwise inverse. The protocol state machine, key storage and the radio layer sit outside this block.

Top module: `filt_lfsr_cipher`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o`, `ks_valid_o`, `byte_valid_o`, `auth_done_o` and `auth_pass_o` are all low.
- R2: The key, serial and IV ports are written with the first transmitted byte in the most significant byte. Each is bit-mirrored across its full width before use. The register is seeded with the mirrored key's low 16 bits in bits 47..32 and the mirrored serial in bits 31..0.
- R3: A `start_i` pulse is accepted in any cycle, including during a running operation, and restarts the seeding. `busy_o` is high for exactly 32 cycles, starting in the cycle after the pulse. In mixing round i (0..31), the register shifts right by one. Its bit 47 then takes the filter output of the shifted value XOR mirrored IV bit i XOR mirrored key bit i+16.
- R4: `step_i` has no effect while `busy_o` is high, or in a cycle where `start_i` or `auth_req_i` is high. No keystream bit appears and no keystream position is consumed.
- R5: Each accepted step shifts the register right by one and loads bit 47 with the XOR of bits 0,2,3,6,7,8,16,22,23,26,30,41,42,43,46,47 of the old state. One cycle later, `ks_valid_o` is high and `ks_bit_o` holds the filter output of the new state. Idle cycles between steps do not change the sequence.
- R6: The filter forms five 4-bit indices from state bits {1,2,4,5}, {7,11,13,14}, {16,20,22,25}, {27,28,30,32} and {33,42,43,45}, with the first listed bit as the index LSB. The first and last index select from table 0x2C79 and the middle three from 0x6671. The five results, first as LSB, select a bit of 0x7907287B. With key 4F4E4D494B52, serial 49435769 and IV 656E4572, the first 16 keystream bytes are D7 23 7F CE 8C D0 37 A9 57 49 C1 E6 48 00 8A B6.
- R7: The first keystream bit after a start goes to bit 7 of a byte. `byte_valid_o` pulses with the eighth bit, and `byte_o` then holds the byte. A start clears a partly filled byte.
- R8: With each keystream bit, `dout_o` equals `din_i` from the accepting cycle XOR that keystream bit.
- R9: `auth_req_i` is accepted when idle and `start_i` is low. It consumes the next 32 keystream bits with `busy_o` high for 32 cycles. `auth_done_o` then pulses for one cycle as `busy_o` falls. `auth_pass_o` goes high only if `auth_word_i` equals the inverse of those 32 bits, with the first bit at bit 31.
- R10: `auth_req_i` while `busy_o` is high has no effect: no `auth_done_o` follows and no keystream is consumed.
- R11: After an authentication, stepping continues with keystream bit 33.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Seed the register and run the mixing rounds |
| key_i | input | 48 | Secret key, first byte in the top byte |
| serial_i | input | 32 | Serial number, first byte in the top byte |
| iv_i | input | 32 | Initialisation vector, first byte in the top byte |
| step_i | input | 1 | Request one keystream bit |
| din_i | input | 1 | Serial data bit combined with the keystream |
| auth_req_i | input | 1 | Start an authenticator check |
| auth_word_i | input | 32 | Authenticator received from the reader |
| busy_o | output | 1 | Mixing or authentication in progress |
| ks_valid_o | output | 1 | Keystream bit valid this cycle |
| ks_bit_o | output | 1 | Keystream bit |
| dout_o | output | 1 | Data bit XOR keystream bit |
| byte_valid_o | output | 1 | A keystream byte was completed |
| byte_o | output | 8 | Completed keystream byte |
| auth_done_o | output | 1 | Authenticator check finished |
| auth_pass_o | output | 1 | Result of the last authenticator check |

## Verification
On every cycle, the assertions check the following:
- the busy window lasts exactly 32 cycles for both mixing and authentication;
- every accepted step, and no other cycle, yields a keystream bit;
- nothing is produced while busy;
- a completed byte carries the current bit in its LSB;
- the data output is the delayed input XOR the keystream;
- the authentication result appears exactly when its last round ends.

Only the bench's scenarios can show that the keystream values are right. These are the published test vector, a reference model under gapped stepping and restarts, the pass and fail verdicts of the authenticator, and the fact that a refused step or refused authentication consumes no keystream position.

// File: rtl/fl_cipher_pkg.sv
package fl_cipher_pkg;

  localparam int STATE_W  = 48;
  localparam int SER_W    = 32;
  localparam int KEY_W    = 48;
  localparam int IV_W     = 32;
  localparam int KEY_LO_W = STATE_W - SER_W;   // key bits seeded into the register
  localparam int KEY_HI_W = KEY_W - KEY_LO_W;  // key bits mixed during rounds

  localparam logic [15:0] NIB_TBL_EDGE = 16'h2C79;
  localparam logic [15:0] NIB_TBL_MID  = 16'h6671;
  localparam logic [31:0] MIX_TBL      = 32'h7907287B;

  typedef logic [STATE_W-1:0] lfsr_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_INIT = 2'd1,
    PH_AUTH = 2'd2
  } phase_t;

  // 4-input lookup; b0 is the index LSB
  function automatic logic nib_lookup(input logic [15:0] tbl, input logic b0,
                                      input logic b1, input logic b2, input logic b3);
    return tbl[{b3, b2, b1, b0}];
  endfunction

  // two-level nonlinear output filter
  function automatic logic filter_out(input lfsr_t s);
    logic [4:0] sel;
    sel[0] = nib_lookup(NIB_TBL_EDGE, s[1],  s[2],  s[4],  s[5]);
    sel[1] = nib_lookup(NIB_TBL_MID,  s[7],  s[11], s[13], s[14]);
    sel[2] = nib_lookup(NIB_TBL_MID,  s[16], s[20], s[22], s[25]);
    sel[3] = nib_lookup(NIB_TBL_MID,  s[27], s[28], s[30], s[32]);
    sel[4] = nib_lookup(NIB_TBL_EDGE, s[33], s[42], s[43], s[45]);
    return MIX_TBL[sel];
  endfunction

  // 16-tap linear feedback on the old state
  function automatic logic feedback(input lfsr_t s);
    return s[0]  ^ s[2]  ^ s[3]  ^ s[6]  ^ s[7]  ^ s[8]  ^ s[16] ^ s[22] ^
           s[23] ^ s[26] ^ s[30] ^ s[41] ^ s[42] ^ s[43] ^ s[46] ^ s[47];
  endfunction

  // right shift with a new top bit
  function automatic lfsr_t shift_in(input lfsr_t s, input logic b);
    return {b, s[STATE_W-1:1]};
  endfunction

endpackage

// File: rtl/fl_lfsr_core.sv
module fl_lfsr_core
  import fl_cipher_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                mix_i,
  input  logic                adv_i,
  input  logic [KEY_W-1:0]    key_i,
  input  logic [SER_W-1:0]    ser_i,
  input  logic [IV_W-1:0]     iv_i,
  output logic                kbit_o
);

  lfsr_t               st_q;
  logic [KEY_HI_W-1:0] kmix_q;
  logic [IV_W-1:0]     ivmix_q;

  lfsr_t st_shift;
  lfsr_t st_run;
  logic  mix_bit;

  always_comb begin
    st_shift = shift_in(st_q, 1'b0);
    mix_bit  = filter_out(st_shift) ^ ivmix_q[0] ^ kmix_q[0];
    st_run   = shift_in(st_q, feedback(st_q));
    kbit_o   = filter_out(st_run);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      kmix_q  <= '0;
      ivmix_q <= '0;
    end else if (load_i) begin
      st_q    <= {key_i[KEY_LO_W-1:0], ser_i};
      kmix_q  <= key_i[KEY_W-1:KEY_LO_W];
      ivmix_q <= iv_i;
    end else if (mix_i) begin
      st_q    <= {mix_bit, st_shift[STATE_W-2:0]};
      kmix_q  <= {1'b0, kmix_q[KEY_HI_W-1:1]};
      ivmix_q <= {1'b0, ivmix_q[IV_W-1:1]};
    end else if (adv_i) begin
      st_q    <= st_run;
    end
  end

endmodule

// File: rtl/fl_seq_ctrl.sv
module fl_seq_ctrl
  import fl_cipher_pkg::*;
#(
  parameter int AUTH_W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic auth_req_i,
  input  logic step_i,
  output logic busy_o,
  output logic load_o,
  output logic mix_o,
  output logic adv_o,
  output logic step_take_o,
  output logic auth_load_o,
  output logic auth_round_o,
  output logic auth_last_o
);

  localparam int MAX_R = (IV_W > AUTH_W) ? IV_W : AUTH_W;
  localparam int RW    = $clog2(MAX_R);
  localparam logic [RW-1:0] INIT_LAST = RW'(IV_W - 1);
  localparam logic [RW-1:0] AUTH_LAST = RW'(AUTH_W - 1);

  phase_t      phase_q;
  logic [RW-1:0] rnd_q;
  logic        last_rnd;

  always_comb begin
    busy_o       = (phase_q != PH_IDLE);
    load_o       = start_i;
    auth_load_o  = !start_i && !busy_o && auth_req_i;
    step_take_o  = !start_i && !busy_o && !auth_req_i && step_i;
    mix_o        = !start_i && (phase_q == PH_INIT);
    auth_round_o = !start_i && (phase_q == PH_AUTH);
    adv_o        = step_take_o || auth_round_o;
    last_rnd     = (phase_q == PH_INIT) ? (rnd_q == INIT_LAST) : (rnd_q == AUTH_LAST);
    auth_last_o  = auth_round_o && last_rnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rnd_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_INIT;
      rnd_q   <= '0;
    end else if (auth_load_o) begin
      phase_q <= PH_AUTH;
      rnd_q   <= '0;
    end else if (busy_o) begin
      rnd_q <= rnd_q + 1'b1;
      if (last_rnd) phase_q <= PH_IDLE;
    end
  end

endmodule

// File: rtl/fl_ks_tap.sv
module fl_ks_tap #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              take_i,
  input  logic              bit_i,
  input  logic              din_i,
  output logic              ks_valid_o,
  output logic              ks_bit_o,
  output logic              dout_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o
);

  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(BYTE_W - 1);

  logic [BYTE_W-2:0] part_q;
  logic [CW-1:0]     cnt_q;
  logic              byte_end;

  assign byte_end = take_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ks_valid_o   <= 1'b0;
      ks_bit_o     <= 1'b0;
      dout_o       <= 1'b0;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
      part_q       <= '0;
      cnt_q        <= '0;
    end else begin
      ks_valid_o   <= take_i;
      byte_valid_o <= byte_end;
      if (clear_i) begin
        cnt_q  <= '0;
        part_q <= '0;
      end else if (take_i) begin
        ks_bit_o <= bit_i;
        dout_o   <= din_i ^ bit_i;
        part_q   <= {part_q[BYTE_W-3:0], bit_i};
        if (byte_end) begin
          byte_o <= {part_q, bit_i};
          cnt_q  <= '0;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fl_auth_cmp.sv
module fl_auth_cmp #(
  parameter int AUTH_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [AUTH_W-1:0] word_i,
  input  logic              round_i,
  input  logic              last_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic              pass_o
);

  logic [AUTH_W-1:0] ref_q;
  logic [AUTH_W-1:0] acc_q;
  logic [AUTH_W-1:0] acc_nxt;

  assign acc_nxt = {acc_q[AUTH_W-2:0], bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      acc_q  <= '0;
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else begin
      done_o <= last_i;
      if (load_i) begin
        ref_q <= word_i;
        acc_q <= '0;
      end else if (round_i) begin
        acc_q <= acc_nxt;
      end
      if (last_i) pass_o <= (acc_nxt == ~ref_q);
    end
  end

endmodule

// File: rtl/filt_lfsr_cipher.sv
module filt_lfsr_cipher
  import fl_cipher_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int AUTH_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [SER_W-1:0]  serial_i,
  input  logic [IV_W-1:0]   iv_i,
  input  logic              step_i,
  input  logic              din_i,
  input  logic              auth_req_i,
  input  logic [AUTH_W-1:0] auth_word_i,
  output logic              busy_o,
  output logic              ks_valid_o,
  output logic              ks_bit_o,
  output logic              dout_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              auth_done_o,
  output logic              auth_pass_o
);

  // inputs arrive first-byte-high; the register wants them mirrored
  logic [KEY_W-1:0] key_m;
  logic [SER_W-1:0] ser_m;
  logic [IV_W-1:0]  iv_m;

  for (genvar b = 0; b < KEY_W; b++) begin : g_key_mirror
    assign key_m[b] = key_i[KEY_W-1-b];
  end
  for (genvar b = 0; b < SER_W; b++) begin : g_ser_mirror
    assign ser_m[b] = serial_i[SER_W-1-b];
  end
  for (genvar b = 0; b < IV_W; b++) begin : g_iv_mirror
    assign iv_m[b] = iv_i[IV_W-1-b];
  end

  // named internal events
  logic do_load;
  logic do_mix;
  logic do_adv;
  logic step_take;
  logic auth_load;
  logic auth_round;
  logic auth_last;
  logic kbit;

  fl_seq_ctrl #(.AUTH_W(AUTH_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .auth_req_i   (auth_req_i),
    .step_i       (step_i),
    .busy_o       (busy_o),
    .load_o       (do_load),
    .mix_o        (do_mix),
    .adv_o        (do_adv),
    .step_take_o  (step_take),
    .auth_load_o  (auth_load),
    .auth_round_o (auth_round),
    .auth_last_o  (auth_last)
  );

  fl_lfsr_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (do_load),
    .mix_i  (do_mix),
    .adv_i  (do_adv),
    .key_i  (key_m),
    .ser_i  (ser_m),
    .iv_i   (iv_m),
    .kbit_o (kbit)
  );

  fl_ks_tap #(.BYTE_W(BYTE_W)) u_tap (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (do_load),
    .take_i       (step_take),
    .bit_i        (kbit),
    .din_i        (din_i),
    .ks_valid_o   (ks_valid_o),
    .ks_bit_o     (ks_bit_o),
    .dout_o       (dout_o),
    .byte_valid_o (byte_valid_o),
    .byte_o       (byte_o)
  );

  fl_auth_cmp #(.AUTH_W(AUTH_W)) u_auth (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (auth_load),
    .word_i  (auth_word_i),
    .round_i (auth_round),
    .last_i  (auth_last),
    .bit_i   (kbit),
    .done_o  (auth_done_o),
    .pass_o  (auth_pass_o)
  );

endmodule

// File: rtl/fl_cipher_chk.sv
module fl_cipher_chk #(
  parameter int INIT_N = 32,
  parameter int AUTH_N = 32
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic auth_req_i,
  input logic din_i,
  input logic busy_o,
  input logic ks_valid_o,
  input logic ks_bit_o,
  input logic dout_o,
  input logic byte_valid_o,
  input logic byte_lsb,
  input logic auth_done_o,
  input logic step_take,
  input logic auth_last
);

  logic [6:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (start_i || (auth_req_i && !busy_o)) busy_run <= '0;
    else if (busy_o && busy_run != 7'h7f) busy_run <= busy_run + 1'b1;
  end

  assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

  assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ((busy_run == 7'(INIT_N)) || (busy_run == 7'(AUTH_N))));

  assert_no_bit_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o || start_i) |=> !ks_valid_o);

  assert_bit_per_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_take |=> ks_valid_o);

  assert_no_stray_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step_take |=> !ks_valid_o);

  assert_byte_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> (ks_valid_o && (byte_lsb == ks_bit_o)));

  assert_data_xor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid_o |-> (dout_o == ($past(din_i) ^ ks_bit_o)));

  assert_auth_done_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    auth_last |=> (auth_done_o && !busy_o));

  assert_auth_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    auth_done_o |-> $fell(busy_o));

endmodule

bind filt_lfsr_cipher fl_cipher_chk #(.INIT_N(32), .AUTH_N(AUTH_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .auth_req_i   (auth_req_i),
  .din_i        (din_i),
  .busy_o       (busy_o),
  .ks_valid_o   (ks_valid_o),
  .ks_bit_o     (ks_bit_o),
  .dout_o       (dout_o),
  .byte_valid_o (byte_valid_o),
  .byte_lsb     (byte_o[0]),
  .auth_done_o  (auth_done_o),
  .step_take    (step_take),
  .auth_last    (auth_last)
);

// File: tb/sim_filt_lfsr_cipher.sv
`timescale 1ns/1ps
module sim_filt_lfsr_cipher;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [47:0] key_i = '0;
  logic [31:0] serial_i = '0;
  logic [31:0] iv_i = '0;
  logic        step_i = 1'b0;
  logic        din_i = 1'b0;
  logic        auth_req_i = 1'b0;
  logic [31:0] auth_word_i = '0;
  logic        busy_o, ks_valid_o, ks_bit_o, dout_o, byte_valid_o;
  logic [7:0]  byte_o;
  logic        auth_done_o, auth_pass_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  filt_lfsr_cipher u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
    .serial_i(serial_i), .iv_i(iv_i), .step_i(step_i), .din_i(din_i),
    .auth_req_i(auth_req_i), .auth_word_i(auth_word_i), .busy_o(busy_o),
    .ks_valid_o(ks_valid_o), .ks_bit_o(ks_bit_o), .dout_o(dout_o),
    .byte_valid_o(byte_valid_o), .byte_o(byte_o),
    .auth_done_o(auth_done_o), .auth_pass_o(auth_pass_o)
  );

  // ---------------- reference model ----------------
  logic [47:0] m_st;
  int unsigned GRP [5][4] = '{'{1,2,4,5}, '{7,11,13,14}, '{16,20,22,25},
                              '{27,28,30,32}, '{33,42,43,45}};
  int unsigned TAP [16] = '{0,2,3,6,7,8,16,22,23,26,30,41,42,43,46,47};
  logic [7:0] VEC [16] = '{8'hD7,8'h23,8'h7F,8'hCE,8'h8C,8'hD0,8'h37,8'hA9,
                           8'h57,8'h49,8'hC1,8'hE6,8'h48,8'h00,8'h8A,8'hB6};
  logic [7:0] got_bytes [16];
  int got_n;

  function automatic logic m_filter(input logic [47:0] s);
    logic [15:0] t;
    logic [31:0] big;
    int unsigned i5, i4;
    big = 32'h7907287B;
    i5 = 0;
    for (int g = 0; g < 5; g++) begin
      t = (g == 0 || g == 4) ? 16'h2C79 : 16'h6671;
      i4 = 0;
      for (int j = 0; j < 4; j++) if (s[GRP[g][j]]) i4 += (1 << j);
      if (t[i4]) i5 += (1 << g);
    end
    return big[i5];
  endfunction

  task automatic m_load(input logic [47:0] k, input logic [31:0] s, input logic [31:0] v);
    logic [47:0] km;
    logic [31:0] sm, vm;
    for (int b = 0; b < 48; b++) km[b] = k[47-b];
    for (int b = 0; b < 32; b++) begin sm[b] = s[31-b]; vm[b] = v[31-b]; end
    m_st = {km[15:0], sm};
    for (int i = 0; i < 32; i++) begin
      m_st = m_st >> 1;
      m_st[47] = m_filter(m_st) ^ vm[i] ^ km[i+16];
    end
  endtask

  function automatic logic m_step();
    logic fb;
    fb = 1'b0;
    for (int t = 0; t < 16; t++) fb ^= m_st[TAP[t]];
    m_st = {fb, m_st[47:1]};
    return m_filter(m_st);
  endfunction

  // ---------------- check helper ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy_o, ks_valid_o, byte_valid_o, auth_done_o, auth_pass_o} == 5'b0,
        "R1", "outputs in reset", {busy_o, ks_valid_o, byte_valid_o, auth_done_o, auth_pass_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, ks_valid_o, byte_valid_o, auth_done_o, auth_pass_o} == 5'b0,
        "R1", "outputs after reset", {busy_o, ks_valid_o, byte_valid_o, auth_done_o, auth_pass_o}, 0);
  endtask

  task automatic t_start(input logic [47:0] k, input logic [31:0] s, input logic [31:0] v,
                         input bit hold_step);
    bit all_busy, no_bits;
    all_busy = 1'b1;
    no_bits  = 1'b1;
    start_i = 1'b1; key_i = k; serial_i = s; iv_i = v; step_i = hold_step;
    m_load(k, s, v);
    for (int c = 1; c <= 32; c++) begin
      @(negedge clk);
      if (c == 1) start_i = 1'b0;
      if (busy_o !== 1'b1) all_busy = 1'b0;
      if (ks_valid_o !== 1'b0) no_bits = 1'b0;
    end
    chk(all_busy, "R3", "busy held for 32 cycles", all_busy, 1);
    @(negedge clk);
    chk(busy_o === 1'b0, "R3", "busy low after 32 cycles", busy_o, 0);
    if (hold_step) begin
      chk(no_bits && ks_valid_o === 1'b0, "R4", "no bit while busy", no_bits, 1);
      step_i = 1'b0;
    end
  endtask

  task automatic t_stream(input int nbits, input int gap_mod, input string req);
    int taken, cyc;
    bit go;
    logic d, e;
    logic [7:0] mb;
    taken = 0; cyc = 0; mb = '0; got_n = 0;
    while (taken < nbits) begin
      go = !(gap_mod != 0 && (cyc % gap_mod) == gap_mod - 1);
      d = 1'($urandom_range(0, 1));
      step_i = go; din_i = d;
      @(negedge clk);
      if (go) begin
        e = m_step();
        mb = {mb[6:0], e};
        taken++;
        chk(ks_valid_o === 1'b1, "R5", "bit valid after step", ks_valid_o, 1);
        chk(ks_bit_o === e, req, "keystream bit", ks_bit_o, e);
        chk(dout_o === (d ^ e), "R8", "data xor keystream", dout_o, d ^ e);
        if (taken % 8 == 0) begin
          chk(byte_valid_o === 1'b1 && byte_o === mb, "R7", "byte completed", byte_o, mb);
          if (got_n < 16) begin got_bytes[got_n] = byte_o; got_n++; end
        end else begin
          chk(byte_valid_o === 1'b0, "R7", "no byte mid-way", byte_valid_o, 0);
        end
      end else begin
        chk(ks_valid_o === 1'b0, "R5", "no bit in gap", ks_valid_o, 0);
      end
      cyc++;
    end
    step_i = 1'b0; din_i = 1'b0;
  endtask

  task automatic t_auth(input logic [31:0] word, input bit exp_pass);
    bit no_early, busy_ok;
    logic b;
    no_early = 1'b1; busy_ok = 1'b1;
    for (int i = 0; i < 32; i++) b = m_step();
    auth_req_i = 1'b1; auth_word_i = word;
    step_i = 1'b1;  // must be ignored while authentication is requested/running
    for (int c = 1; c <= 33; c++) begin
      @(negedge clk);
      if (c == 1) auth_req_i = 1'b0;
      if (c < 33) begin
        if (auth_done_o !== 1'b0) no_early = 1'b0;
        if (busy_o !== 1'b1 || ks_valid_o !== 1'b0) busy_ok = 1'b0;
      end
      if (c == 32) step_i = 1'b0;
    end
    chk(no_early && busy_ok, "R9", "busy without result for 32 cycles", busy_ok, 1);
    chk(auth_done_o === 1'b1 && busy_o === 1'b0, "R9", "done as busy falls", auth_done_o, 1);
    chk(auth_pass_o === exp_pass, "R9", "pass verdict", auth_pass_o, exp_pass);
    @(negedge clk);
    chk(auth_done_o === 1'b0, "R9", "done is one pulse", auth_done_o, 0);
  endtask

  task automatic t_restart();
    start_i = 1'b1; key_i = 48'h0123456789AB; serial_i = 32'hDEADBEEF; iv_i = 32'h13579BDF;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    t_start(48'hA5A55A5AC3C3, 32'h0F1E2D3C, 32'h89ABCDEF, 1'b0);
    t_stream(16, 0, "R3");
  endtask

  task automatic t_auth_busy();
    bit quiet;
    quiet = 1'b1;
    start_i = 1'b1; key_i = 48'h112233445566; serial_i = 32'hCAFEF00D; iv_i = 32'h76543210;
    m_load(key_i, serial_i, iv_i);
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      if (c == 1) start_i = 1'b0;
      if (c == 5) begin auth_req_i = 1'b1; auth_word_i = 32'h12345678; end
      if (c == 6) auth_req_i = 1'b0;
      if (auth_done_o !== 1'b0) quiet = 1'b0;
    end
    chk(quiet, "R10", "no result from refused request", quiet, 1);
    chk(busy_o === 1'b0, "R10", "idle after init", busy_o, 0);
    t_stream(16, 0, "R10");
  endtask

  // ---------------- main ----------------
  initial begin
    t_reset_state();

    // R2 R6: published vector through the port bit order
    t_start(48'h4F4E4D494B52, 32'h49435769, 32'h656E4572, 1'b0);
    t_stream(128, 0, "R6");
    for (int i = 0; i < 16; i++)
      chk(got_bytes[i] === VEC[i], "R2 R6", "vector byte", got_bytes[i], VEC[i]);

    // R9 R11: correct authenticator, then continuation
    t_start(48'h4F4E4D494B52, 32'h49435769, 32'h656E4572, 1'b0);
    t_auth(32'h28DC8031, 1'b1);
    t_stream(32, 0, "R11");
    for (int i = 0; i < 4; i++)
      chk(got_bytes[i] === VEC[i+4], "R11", "byte after auth", got_bytes[i], VEC[i+4]);

    // R9: one bit wrong
    t_start(48'h4F4E4D494B52, 32'h49435769, 32'h656E4572, 1'b0);
    t_auth(32'h28DC8030, 1'b0);

    // R4 R5: step held through seeding, then gapped stepping
    t_start(48'h9E3779B97F4A, 32'h7C15A3E2, 32'h2545F491, 1'b1);
    t_stream(40, 3, "R5");

    // R7: partial byte cleared by a new start
    t_stream(3, 0, "R5");
    t_start(48'h31415926535A, 32'h27182818, 32'h16180339, 1'b0);
    t_stream(16, 0, "R7");

    // R3: restart during seeding
    t_restart();

    // R10: refused authentication request
    t_auth_busy();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule